// File: doc/BRIEF.md
# Secure-Masked Interrupt State Bitmaps

This block holds the enable, pending and active state of every shared interrupt as 32-bit words. Software reaches the words through a small register port. Each of the three bitmaps appears at two addresses. The set alias ORs the written ones into the bitmap. The clear alias removes the written ones. Reading either alias returns the current bitmap word. Three outputs carry the full bitmaps to the downstream prioritisation logic, which is not part of this block.

Every access is filtered bit by bit according to who makes it. A secure access sees all bits. So does any access while the global security-disable input is high. A non-secure access reaches a bit only if that interrupt belongs to the non-secure group, or if the interrupt's 2-bit non-secure permission level is high enough for the register being used. The pending view also folds in the live input line for level-sensitive interrupts. A rising edge on an edge-configured line latches pending without any software action.

Top module: `irq_state_bitmaps`

## Requirements
- R1: The byte address `regAddr` selects the bitmap bank in bits [9:7]: 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 set-active, 5 clear-active. Bits [6:2] give the word index, and the word covers interrupt IDs index×32 to index×32+31, with bit n standing for ID index×32+n. Reads of a set alias and of its clear alias return the same word. Bank codes 6 and 7 read as zero and ignore writes.
- R2: A write to a set alias sets every permitted bit whose write-data bit is 1. Data bits that are 0 leave the bitmap unchanged.
- R3: A write to a clear alias clears every permitted bit whose write-data bit is 1. A clear never sets a bit, and a set never clears one.
- R4: A word whose index is 0, or whose first ID is at or above NUM_IRQ, reads as zero and ignores writes.
- R5: When `regSecure` is 1 or `secDisable` is 1, every bit of the word is permitted.
- R6: For a non-secure access while `secDisable` is 0, the enable banks permit exactly the bits whose `groupBits` entry is 1. Bits that are not permitted read as zero and keep their value.
- R7: The permission level of interrupt i is `nsAccess[2i+1:2i]`. Under the conditions of R6, set-pending reads and writes permit bits where the group bit is 1 or the level is nonzero.
- R8: Under the conditions of R6, clear-pending reads and writes permit bits where the group bit is 1 or the level is 2 or 3. Reads of either active alias use the same test. Writes to either active alias use the group bit alone.
- R9: The pending value seen on reads and on `pendingOut` is the pending latch ORed with (`irqLevel` AND NOT `edgeCfg`), where an `edgeCfg` bit of 1 marks an edge-triggered line. Lines below ID 32 are ignored.
- R10: A 0-to-1 change on an edge-configured `irqLevel` line sets its pending latch one clock later. A level that stays high does not set the latch again after it is cleared. The edge wins over a clear-pending write in the same cycle.
- R11: Writes take effect on the next clock edge. `regRdata` is registered: it shows the read word after the clock edge that samples a read, and holds its value while no read is made.
- R12: After reset, all bitmaps and `regRdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Access strobe |
| regWrite | input | 1 | 1 write, 0 read |
| regSecure | input | 1 | Access is secure |
| regAddr | input | 10 | Byte address (bank and word) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| secDisable | input | 1 | Single security state: no masking |
| groupBits | input | NUM_IRQ | 1 = interrupt is non-secure group |
| nsAccess | input | 2×NUM_IRQ | Non-secure permission level per interrupt |
| edgeCfg | input | NUM_IRQ | 1 = edge-triggered, 0 = level-sensitive |
| irqLevel | input | NUM_IRQ | Live interrupt input lines |
| enableOut | output | NUM_IRQ | Enable bitmap |
| pendingOut | output | NUM_IRQ | Effective pending bitmap |
| activeOut | output | NUM_IRQ | Active bitmap |

## Verification
The bench builds the block with NUM_IRQ = 96. This gives one internal word (index 0), two live words (1 and 2), and word 3 as the first word past the implemented count, so both out-of-range edges are reachable with single accesses. Word 1 is configured with four eight-bit bands: group bit only, permission level 1, level 2 and level 3. One write and read pair can therefore show all three mask tests at once. Word 2 has no group bits and no permission, which exposes full masking. It also holds a level-sensitive line used to check the merged pending view.

// File: rtl/irqbm_pkg.sv
package irqbm_pkg;
  localparam int WORD_BITS  = 32;
  localparam int WORD_IDX_W = 5;

  localparam logic [2:0] BANK_SET_EN   = 3'd0;
  localparam logic [2:0] BANK_CLR_EN   = 3'd1;
  localparam logic [2:0] BANK_SET_PEND = 3'd2;
  localparam logic [2:0] BANK_CLR_PEND = 3'd3;
  localparam logic [2:0] BANK_SET_ACT  = 3'd4;
  localparam logic [2:0] BANK_CLR_ACT  = 3'd5;

  typedef enum logic [1:0] {TG_ENABLE, TG_PEND, TG_ACTIVE, TG_NONE} target_e;
  typedef enum logic [1:0] {MK_GROUP, MK_GE1, MK_GE2} maskKind_e;

  typedef struct packed {
    logic                  doSet;
    logic                  doClr;
    logic                  doRead;
    logic                  rdLive;
    target_e               target;
    maskKind_e             maskKind;
    logic [WORD_IDX_W-1:0] word;
    logic                  secure;
  } strobe_t;
endpackage

// File: rtl/irqbm_ctrl.sv
module irqbm_ctrl
  import irqbm_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regValid,
  input  logic       regWrite,
  input  logic       regSecure,
  input  logic [9:0] regAddr,
  output strobe_t    st
);
  localparam int NUM_WORDS = NUM_IRQ / WORD_BITS;

  target_e   target;
  maskKind_e kind;
  logic      isSetAlias;
  logic      inRange;
  logic [WORD_IDX_W-1:0] wordIdx;

  assign wordIdx = regAddr[6:2];
  assign inRange = (wordIdx != '0) && (int'(wordIdx) < NUM_WORDS);

  always_comb begin
    target     = TG_NONE;
    kind       = MK_GROUP;
    isSetAlias = 1'b0;
    case (regAddr[9:7])
      BANK_SET_EN:   begin target = TG_ENABLE; isSetAlias = 1'b1; end
      BANK_CLR_EN:   begin target = TG_ENABLE; end
      BANK_SET_PEND: begin target = TG_PEND; kind = MK_GE1; isSetAlias = 1'b1; end
      BANK_CLR_PEND: begin target = TG_PEND; kind = MK_GE2; end
      BANK_SET_ACT:  begin target = TG_ACTIVE; isSetAlias = 1'b1;
                           kind = regWrite ? MK_GROUP : MK_GE2; end
      BANK_CLR_ACT:  begin target = TG_ACTIVE;
                           kind = regWrite ? MK_GROUP : MK_GE2; end
      default:       begin target = TG_NONE; end
    endcase
  end

  always_comb begin
    st          = '0;
    st.target   = target;
    st.maskKind = kind;
    st.word     = wordIdx;
    st.secure   = regSecure;
    st.rdLive   = inRange && (target != TG_NONE);
    st.doRead   = regValid && !regWrite;
    st.doSet    = regValid && regWrite && st.rdLive && isSetAlias;
    st.doClr    = regValid && regWrite && st.rdLive && !isSetAlias;
  end

  // R1: at most one operation per access
  assert_one_op_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.doSet, st.doClr, st.doRead}));

  // R4: internal word never receives a write strobe
  assert_no_word0_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && regAddr[6:2] == '0) |-> !(st.doSet || st.doClr));
endmodule

// File: rtl/irqbm_datapath.sv
module irqbm_datapath
  import irqbm_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              st,
  input  logic [31:0]          wdata,
  input  logic                 secDisable,
  input  logic [NUM_IRQ-1:0]   groupBits,
  input  logic [2*NUM_IRQ-1:0] nsAccess,
  input  logic [NUM_IRQ-1:0]   edgeCfg,
  input  logic [NUM_IRQ-1:0]   irqLevel,
  output logic [31:0]          rdata,
  output logic [NUM_IRQ-1:0]   enableOut,
  output logic [NUM_IRQ-1:0]   pendingOut,
  output logic [NUM_IRQ-1:0]   activeOut
);
  localparam int NUM_WORDS = NUM_IRQ / WORD_BITS;
  localparam logic [NUM_IRQ-1:0] EXT_MASK = {{(NUM_IRQ-WORD_BITS){1'b1}}, {WORD_BITS{1'b0}}};

  logic [NUM_IRQ-1:0] enableQ, pendQ, activeQ, levelQ;
  logic [NUM_IRQ-1:0] enNext, pendNext, actNext;
  logic [NUM_IRQ-1:0] lineOk, edgeRise, pendEff;
  logic [31:0] selGroup, selEn, selPend, selAct, ge1, ge2, permBits, accMask, wMask, rdNext;
  logic [63:0] selNs;
  logic [31:0] rdataQ;
  logic        restricted;

  assign lineOk   = irqLevel & EXT_MASK;
  assign edgeRise = edgeCfg & lineOk & ~levelQ;
  assign pendEff  = pendQ | (lineOk & ~edgeCfg);

  // word select
  always_comb begin
    selGroup = '0; selNs = '0; selEn = '0; selPend = '0; selAct = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (int'(st.word) == w) begin
        selGroup = groupBits[w*32 +: 32];
        selNs    = nsAccess[w*64 +: 64];
        selEn    = enableQ[w*32 +: 32];
        selPend  = pendEff[w*32 +: 32];
        selAct   = activeQ[w*32 +: 32];
      end
    end
  end

  // permission tests per interrupt
  always_comb begin
    for (int b = 0; b < 32; b++) begin
      ge1[b] = selNs[2*b] | selNs[2*b+1];
      ge2[b] = selNs[2*b+1];
    end
  end

  always_comb begin
    case (st.maskKind)
      MK_GE1:  permBits = ge1;
      MK_GE2:  permBits = ge2;
      default: permBits = '0;
    endcase
    restricted = !st.secure && !secDisable;
    accMask    = restricted ? (selGroup | permBits) : '1;
    wMask      = wdata & accMask;
    case (st.target)
      TG_ENABLE: rdNext = selEn & accMask;
      TG_PEND:   rdNext = selPend & accMask;
      TG_ACTIVE: rdNext = selAct & accMask;
      default:   rdNext = '0;
    endcase
    if (!st.rdLive) rdNext = '0;
  end

  // next state
  always_comb begin
    enNext   = enableQ;
    pendNext = pendQ;
    actNext  = activeQ;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (int'(st.word) == w) begin
        if (st.doSet) begin
          case (st.target)
            TG_ENABLE: enNext[w*32 +: 32]   = enableQ[w*32 +: 32] | wMask;
            TG_PEND:   pendNext[w*32 +: 32] = pendQ[w*32 +: 32] | wMask;
            TG_ACTIVE: actNext[w*32 +: 32]  = activeQ[w*32 +: 32] | wMask;
            default: ;
          endcase
        end else if (st.doClr) begin
          case (st.target)
            TG_ENABLE: enNext[w*32 +: 32]   = enableQ[w*32 +: 32] & ~wMask;
            TG_PEND:   pendNext[w*32 +: 32] = pendQ[w*32 +: 32] & ~wMask;
            TG_ACTIVE: actNext[w*32 +: 32]  = activeQ[w*32 +: 32] & ~wMask;
            default: ;
          endcase
        end
      end
    end
    pendNext = pendNext | edgeRise;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      pendQ   <= '0;
      activeQ <= '0;
      levelQ  <= '0;
      rdataQ  <= '0;
    end else begin
      enableQ <= enNext;
      pendQ   <= pendNext;
      activeQ <= actNext;
      levelQ  <= lineOk;
      if (st.doRead) rdataQ <= rdNext;
    end
  end

  assign rdata      = rdataQ;
  assign enableOut  = enableQ;
  assign pendingOut = pendEff;
  assign activeOut  = activeQ;

  // R3: a set never clears enable or active bits
  assert_set_no_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    st.doSet |=> ((($past(enableQ) & ~enableQ) | ($past(activeQ) & ~activeQ)) == '0));

  // R3: a clear never sets enable or active bits
  assert_clr_no_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    st.doClr |=> (((enableQ & ~$past(enableQ)) | (activeQ & ~$past(activeQ))) == '0));

  // R10: pending latch falls only after a clear-pending write
  assert_pend_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(st.doClr && st.target == TG_PEND) |=> (($past(pendQ) & ~pendQ) == '0));

  // R10: an edge on an edge-configured line is latched
  assert_edge_latch_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeRise) |=> (($past(edgeRise) & ~pendQ) == '0));

  // R4: out-of-range reads return zero
  assert_oor_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (st.doRead && !st.rdLive) |=> (rdataQ == '0));

  // R6: non-secure enable writes leave secure-group bits alone
  assert_masked_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((st.doSet || st.doClr) && st.target == TG_ENABLE && !st.secure && !secDisable)
    |=> (((enableQ ^ $past(enableQ)) & ~$past(groupBits)) == '0));
endmodule

// File: rtl/irq_state_bitmaps.sv
module irq_state_bitmaps
  import irqbm_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regValid,
  input  logic                 regWrite,
  input  logic                 regSecure,
  input  logic [9:0]           regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic                 secDisable,
  input  logic [NUM_IRQ-1:0]   groupBits,
  input  logic [2*NUM_IRQ-1:0] nsAccess,
  input  logic [NUM_IRQ-1:0]   edgeCfg,
  input  logic [NUM_IRQ-1:0]   irqLevel,
  output logic [NUM_IRQ-1:0]   enableOut,
  output logic [NUM_IRQ-1:0]   pendingOut,
  output logic [NUM_IRQ-1:0]   activeOut
);
  strobe_t st;

  irqbm_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regSecure(regSecure), .regAddr(regAddr), .st(st)
  );

  irqbm_datapath #(.NUM_IRQ(NUM_IRQ)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wdata(regWdata), .secDisable(secDisable),
    .groupBits(groupBits), .nsAccess(nsAccess), .edgeCfg(edgeCfg), .irqLevel(irqLevel),
    .rdata(regRdata), .enableOut(enableOut), .pendingOut(pendingOut), .activeOut(activeOut)
  );
endmodule

// File: tb/irq_state_bitmaps_tb.sv
module irq_state_bitmaps_tb;
  localparam int NUM_IRQ = 96;

  logic clk = 1'b0;
  logic rstN;
  logic regValid, regWrite, regSecure;
  logic [9:0] regAddr;
  logic [31:0] regWdata, regRdata;
  logic secDisable;
  logic [NUM_IRQ-1:0] groupBits, edgeCfg, irqLevel, enableOut, pendingOut, activeOut;
  logic [2*NUM_IRQ-1:0] nsAccess;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_state_bitmaps #(.NUM_IRQ(NUM_IRQ)) u_dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regSecure(regSecure), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .secDisable(secDisable), .groupBits(groupBits), .nsAccess(nsAccess),
    .edgeCfg(edgeCfg), .irqLevel(irqLevel), .enableOut(enableOut),
    .pendingOut(pendingOut), .activeOut(activeOut)
  );

  typedef struct packed {
    logic        wrSec;
    logic [9:0]  wrAddr;
    logic [31:0] wrData;
    logic        rdSec;
    logic [9:0]  rdAddr;
    logic [31:0] expData;
    logic [7:0]  req;
  } vec_t;

  // word1 masks (non-secure): enable FF, set-pend FFFFFFFF, clr-pend/active-read FFFF00FF, active-write FF
  localparam vec_t VECS [17] = '{
    '{1'b1, 10'h004, 32'hFFFF_FFFF, 1'b1, 10'h004, 32'hFFFF_FFFF, 8'd2},  // R2 R5
    '{1'b0, 10'h084, 32'hFFFF_FFFF, 1'b1, 10'h084, 32'hFFFF_FF00, 8'd6},  // R6 R3
    '{1'b1, 10'h004, 32'h0000_0000, 1'b0, 10'h004, 32'h0000_0000, 8'd6},  // R6 read mask, R2 zero
    '{1'b1, 10'h084, 32'h0000_FF00, 1'b1, 10'h004, 32'hFFFF_0000, 8'd3},  // R3
    '{1'b0, 10'h104, 32'h1234_5678, 1'b1, 10'h104, 32'h1234_5678, 8'd7},  // R7
    '{1'b0, 10'h184, 32'hFFFF_FFFF, 1'b1, 10'h184, 32'h0000_5600, 8'd8},  // R8
    '{1'b1, 10'h104, 32'h8000_0000, 1'b0, 10'h104, 32'h8000_5600, 8'd7},  // R7
    '{1'b1, 10'h104, 32'h0000_0000, 1'b0, 10'h184, 32'h8000_0000, 8'd8},  // R8
    '{1'b0, 10'h204, 32'hFFFF_FFFF, 1'b1, 10'h204, 32'h0000_00FF, 8'd8},  // R8 active write
    '{1'b1, 10'h204, 32'h0F0F_0F00, 1'b0, 10'h284, 32'h0F0F_00FF, 8'd8},  // R8 active read
    '{1'b0, 10'h284, 32'hFFFF_FFFF, 1'b1, 10'h204, 32'h0F0F_0F00, 8'd8},  // R8
    '{1'b0, 10'h008, 32'hFFFF_FFFF, 1'b1, 10'h008, 32'h0000_0000, 8'd6},  // R6 word2
    '{1'b1, 10'h008, 32'hA5A5_A5A5, 1'b0, 10'h008, 32'h0000_0000, 8'd6},  // R6
    '{1'b1, 10'h00C, 32'hFFFF_FFFF, 1'b1, 10'h00C, 32'h0000_0000, 8'd4},  // R4 top
    '{1'b1, 10'h000, 32'hFFFF_FFFF, 1'b1, 10'h000, 32'h0000_0000, 8'd4},  // R4 word0
    '{1'b1, 10'h304, 32'hFFFF_FFFF, 1'b1, 10'h304, 32'h0000_0000, 8'd1},  // R1 bank6
    '{1'b1, 10'h008, 32'h0000_0000, 1'b1, 10'h088, 32'hA5A5_A5A5, 8'd1}   // R1 alias
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic sec, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regSecure = sec; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic regRd(input logic sec, input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regSecure = sec; regAddr = a;
    @(negedge clk);
    regValid = 1'b0;
    d = regRdata;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rstN = 1'b0; regValid = 1'b0; regWrite = 1'b0; regSecure = 1'b0;
    regAddr = '0; regWdata = '0; secDisable = 1'b0; irqLevel = '0;
    groupBits = '0; groupBits[39:32] = 8'hFF;
    nsAccess = '0; nsAccess[127:64] = 64'hFFFF_AAAA_5555_0000;
    edgeCfg = '1; edgeCfg[64] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R12 rdata", regRdata, 32'h0);
    check("R12 enable", enableOut[63:32] | activeOut[63:32] | pendingOut[63:32], 32'h0);

    for (int i = 0; i < 17; i++) begin
      regWr(VECS[i].wrSec, VECS[i].wrAddr, VECS[i].wrData);
      regRd(VECS[i].rdSec, VECS[i].rdAddr, rd);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].expData);
    end

    // R11: rdata holds across a write and idle cycles
    regWr(1'b1, 10'h004, 32'h0000_0001);
    repeat (2) @(negedge clk);
    check("R11 hold", regRdata, 32'hA5A5_A5A5);
    // R11: write visible on the next clock edge
    check("R11 write timing", enableOut[63:32], 32'hFFFF_0001);

    // R5: secDisable opens non-secure access to word2
    secDisable = 1'b1;
    regWr(1'b0, 10'h008, 32'h0000_0002);
    regRd(1'b0, 10'h008, rd);
    check("R5 secDisable", rd, 32'hA5A5_A5A7);

    // R9: level-sensitive line 64 merges into pending
    irqLevel[64] = 1'b1;
    regRd(1'b1, 10'h108, rd);
    check("R9 level read", rd, 32'h0000_0001);
    regWr(1'b1, 10'h188, 32'h0000_0001);
    regRd(1'b1, 10'h188, rd);
    check("R9 level persists", rd, 32'h0000_0001);
    irqLevel[64] = 1'b0;
    @(negedge clk);
    check("R9 level gone", {31'b0, pendingOut[64]}, 32'h0);

    // R10: edge latch on line 33
    irqLevel[33] = 1'b1;
    @(negedge clk);
    check("R10 edge sets", {31'b0, pendingOut[33]}, 32'h1);
    regWr(1'b1, 10'h184, 32'h0000_0002);
    repeat (2) @(negedge clk);
    check("R10 held level ignored", {31'b0, pendingOut[33]}, 32'h0);
    irqLevel[33] = 1'b0;
    @(negedge clk);
    // R10: edge beats a same-cycle clear
    irqLevel[33] = 1'b1;
    regValid = 1'b1; regWrite = 1'b1; regSecure = 1'b1; regAddr = 10'h184; regWdata = 32'h2;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
    check("R10 edge wins", {31'b0, pendingOut[33]}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule